// File: doc/BRIEF.md
# RTC Indexed Register Port

This block sits between a byte-wide host bus and the register file of a real-time clock. The host sees only two addresses. A write to the even address selects a register index. A read or write at the odd address then reaches the selected byte. Behind the port is a store of `NUM_REGS` bytes. Most of it is plain storage. The calendar and alarm fields sit at fixed low indexes, and four control/status bytes (indexes 10 to 13) have their own side effects.

The calendar counter and the periodic rate generator are separate blocks. They connect to this port through plain pins:
- The time and alarm bytes are brought out.
- A calendar update input writes the seven time bytes back.
- Update-in-progress set and clear inputs drive the status bit.
- Three event inputs (periodic, alarm, update-ended) raise flags in the status byte.
- A one-cycle `load_o` pulse tells the calendar to reload itself from the time bytes.
- `set_mode_o` reports that the host has frozen the clock for setting.

Accesses use single-cycle strobes. Read data is registered and appears on the cycle after `rd_en`. There is no back-pressure: every strobe completes in the cycle it is given.

Top module: `rtc_regport`

## Requirements
- R1: A write at `addr`=0 loads the index with `wdata[6:0]`, so bit 7 of the data is ignored. A read at `addr`=0 returns 0xFF. All read data appears on `rdata` the cycle after `rd_en`.
- R2: Every index other than 10 to 13 is a plain byte. A write at `addr`=1 stores `wdata`, and a later read at `addr`=1 returns it, up to index 0x7F.
- R3: Bit 7 of control byte A (index 10, update in progress) is read-only. A host write to A replaces bits 6:0 and keeps bit 7.
- R4: Host writes to control bytes C (index 12) and D (index 13) have no effect.
- R5: A read of C returns its current value. After that read, C is 0x00 and `irq_o` is low, unless an event arrives in the same cycle.
- R6: A write to control byte B (index 11) with bit 7 (SET) high stores the data with bit 4 (update-ended enable) forced to 0, and clears bit 7 of A.
- R7: A write to B with bit 7 low, made while B bit 7 was high, pulses `load_o` for one cycle, starting the cycle after the write.
- R8: While B bit 7 is low, a host write to a time byte pulses `load_o` the cycle after. The time bytes are at indexes 0, 2, 4, 6, 7, 8 and 9 (seconds, minutes, hours, weekday, day, month, year). While B bit 7 is high, such a write gives no pulse.
- R9: After reset the control bytes read A=0x26, B=0x02, C=0x00 and D=0x80.
- R10: An event pulse is enabled by its bit in B: periodic by bit 6, alarm by bit 5, update-ended by bit 4. An enabled event sets its flag in C (bit 6, bit 5 or bit 4 respectively), sets C bit 7, and raises `irq_o`, which follows C bit 7. A disabled event changes neither C nor `irq_o`.
- R11: While B bit 7 is low, `cal_upd_i` writes `cal_time_i` into the seven time bytes and `uip_set_i` sets A bit 7. While B bit 7 is high, both are ignored. `uip_clr_i` clears A bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 1 | 0 selects the index, 1 selects the data byte |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, high while C bit 7 is set |
| evt_per_i | input | 1 | Periodic event pulse |
| evt_alm_i | input | 1 | Alarm match event pulse |
| evt_upd_i | input | 1 | Update-ended event pulse |
| uip_set_i | input | 1 | Calendar starts an update |
| uip_clr_i | input | 1 | Calendar finished an update |
| cal_upd_i | input | 1 | Calendar writes back its time bytes |
| cal_time_i | input | 56 | Time bytes to write back; byte 0 is seconds, byte 6 is year |
| time_o | output | 56 | Stored time bytes, in the same order |
| alarm_o | output | 24 | Alarm bytes: seconds, minutes, hours |
| ctrl_a_o | output | 8 | Control byte A |
| ctrl_b_o | output | 8 | Control byte B |
| load_o | output | 1 | One-cycle request to reload the calendar |
| set_mode_o | output | 1 | B bit 7, the clock is frozen for setting |

## Verification
The bench builds the block with the default `NUM_REGS` of 128, which gives a 7-bit index. At that width, index 0x7F is reachable as plain storage. It also lets an index write with data bit 7 set alias back onto a lower byte, which shows that the upper bit is dropped. The size also keeps all four control bytes and every time byte inside the store, so each side-effect rule can be reached through the two bus addresses alone.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int DW       = 8;
  localparam int NUM_TIME = 7;
  localparam int NUM_ALM  = 3;

  localparam int IX_SEC   = 0;
  localparam int IX_ASEC  = 1;
  localparam int IX_MIN   = 2;
  localparam int IX_AMIN  = 3;
  localparam int IX_HOUR  = 4;
  localparam int IX_AHOUR = 5;
  localparam int IX_WDAY  = 6;
  localparam int IX_MDAY  = 7;
  localparam int IX_MON   = 8;
  localparam int IX_YEAR  = 9;
  localparam int IX_CA    = 10;
  localparam int IX_CB    = 11;
  localparam int IX_CC    = 12;
  localparam int IX_CD    = 13;

  localparam logic [DW-1:0] RST_CA = 8'h26;
  localparam logic [DW-1:0] RST_CB = 8'h02;
  localparam logic [DW-1:0] RST_CD = 8'h80;

  localparam int B_SET = 7;
  localparam int B_PIE = 6;
  localparam int B_AIE = 5;
  localparam int B_UIE = 4;
  localparam int A_UIP = 7;

  // slot of a time byte inside the packed time vector, -1 if not a time byte
  function automatic int time_slot(input int idx);
    case (idx)
      IX_SEC:  return 0;
      IX_MIN:  return 1;
      IX_HOUR: return 2;
      IX_WDAY: return 3;
      IX_MDAY: return 4;
      IX_MON:  return 5;
      IX_YEAR: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic int alarm_slot(input int idx);
    case (idx)
      IX_ASEC:  return 0;
      IX_AMIN:  return 1;
      IX_AHOUR: return 2;
      default:  return -1;
    endcase
  endfunction

  function automatic bit is_ctrl(input int idx);
    return (idx >= IX_CA) && (idx <= IX_CD);
  endfunction
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [7:0]       data_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      idx_o <= '0;
    else if (load_i) idx_o <= data_i[IDX_W-1:0];
  end

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (idx_o == $past(data_i[IDX_W-1:0]))); // R1
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
  import rtc_regport_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int IDX_W    = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DW-1:0]          data_i,
  input  logic                   cal_we_i,
  input  logic [NUM_TIME*DW-1:0] cal_time_i,
  output logic [DW-1:0]          rd_byte_o,
  output logic [NUM_TIME*DW-1:0] time_o,
  output logic [NUM_ALM*DW-1:0]  alarm_o
);
  logic [DW-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    localparam int TS = time_slot(g);
    localparam int AS = alarm_slot(g);
    if (is_ctrl(g)) begin : g_ctrl
      assign mem[g] = '0;
    end else begin : g_data
      logic hit;
      assign hit = wr_i && (idx_i == IDX_W'(g));
      if (TS >= 0) begin : g_time
        always_ff @(posedge clk) begin
          if (!rst_n)        mem[g] <= '0;
          else if (hit)      mem[g] <= data_i;
          else if (cal_we_i) mem[g] <= cal_time_i[TS*DW +: DW];
        end
        assign time_o[TS*DW +: DW] = mem[g];
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (!rst_n)   mem[g] <= '0;
          else if (hit) mem[g] <= data_i;
        end
      end
      if (AS >= 0) begin : g_alm
        assign alarm_o[AS*DW +: DW] = mem[g];
      end
    end
  end

  assign rd_byte_o = mem[idx_i];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a_i,
  input  logic          wr_b_i,
  input  logic          wr_cd_i,
  input  logic          rd_c_i,
  input  logic          time_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          uip_set_i,
  input  logic          uip_clr_i,
  input  logic          evt_per_i,
  input  logic          evt_alm_i,
  input  logic          evt_upd_i,
  output logic [DW-1:0] reg_a_o,
  output logic [DW-1:0] reg_b_o,
  output logic [DW-1:0] reg_c_o,
  output logic          load_o
);
  logic       set_now;
  logic [2:0] new_flags;
  logic       uip_nxt;

  assign set_now   = reg_b_o[B_SET];
  assign new_flags = {evt_per_i & reg_b_o[B_PIE],
                      evt_alm_i & reg_b_o[B_AIE],
                      evt_upd_i & reg_b_o[B_UIE]};

  always_comb begin
    uip_nxt = reg_a_o[A_UIP];
    if (wr_b_i && wdata_i[B_SET])      uip_nxt = 1'b0;
    else if (uip_clr_i)                uip_nxt = 1'b0;
    else if (uip_set_i && !set_now)    uip_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a_o <= RST_CA;
      reg_b_o <= RST_CB;
      reg_c_o <= '0;
      load_o  <= 1'b0;
    end else begin
      reg_a_o[A_UIP] <= uip_nxt;
      if (wr_a_i) reg_a_o[A_UIP-1:0] <= wdata_i[A_UIP-1:0];
      if (wr_b_i) begin
        reg_b_o <= wdata_i;
        if (wdata_i[B_SET]) reg_b_o[B_UIE] <= 1'b0;
      end
      reg_c_o <= (rd_c_i ? '0 : reg_c_o) | {|new_flags, new_flags, 4'b0};
      load_o  <= (wr_b_i && !wdata_i[B_SET] && set_now) || (time_wr_i && !set_now);
    end
  end

  AST_UIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_i && !uip_set_i && !uip_clr_i) |=> $stable(reg_a_o[A_UIP])); // R3
  AST_CD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cd_i && !evt_per_i && !evt_alm_i && !evt_upd_i) |=> $stable(reg_c_o)); // R4
  AST_C_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c_i && !evt_per_i && !evt_alm_i && !evt_upd_i) |=> (reg_c_o == '0)); // R5
  AST_SET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b_i && wdata_i[B_SET]) |=> (!reg_b_o[B_UIE] && !reg_a_o[A_UIP])); // R6
  AST_SET_EXIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b_i && !wdata_i[B_SET] && set_now) |=> load_o); // R7
  AST_FROZEN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (time_wr_i && set_now) |=> !load_o); // R8
  AST_FLAG_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_flags) |=> reg_c_o[7]); // R10
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int NUM_REGS = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic                   addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic                   irq_o,
  input  logic                   evt_per_i,
  input  logic                   evt_alm_i,
  input  logic                   evt_upd_i,
  input  logic                   uip_set_i,
  input  logic                   uip_clr_i,
  input  logic                   cal_upd_i,
  input  logic [55:0]            cal_time_i,
  output logic [55:0]            time_o,
  output logic [23:0]            alarm_o,
  output logic [7:0]             ctrl_a_o,
  output logic [7:0]             ctrl_b_o,
  output logic                   load_o,
  output logic                   set_mode_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic             wr_dat, rd_dat;
  logic             sel_a, sel_b, sel_c, sel_d, sel_ctrl, sel_time;
  logic [DW-1:0]    reg_c, store_byte;

  assign wr_dat = wr_en && addr;
  assign rd_dat = rd_en && addr;
  assign sel_a  = (idx == IDX_W'(IX_CA));
  assign sel_b  = (idx == IDX_W'(IX_CB));
  assign sel_c  = (idx == IDX_W'(IX_CC));
  assign sel_d  = (idx == IDX_W'(IX_CD));
  assign sel_ctrl = sel_a || sel_b || sel_c || sel_d;
  assign sel_time = (idx == IDX_W'(IX_SEC))  || (idx == IDX_W'(IX_MIN))  ||
                    (idx == IDX_W'(IX_HOUR)) || (idx == IDX_W'(IX_WDAY)) ||
                    (idx == IDX_W'(IX_MDAY)) || (idx == IDX_W'(IX_MON))  ||
                    (idx == IDX_W'(IX_YEAR));

  rtc_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .load_i(wr_en && !addr), .data_i(wdata), .idx_o(idx)
  );

  rtc_byte_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_i(wr_dat && !sel_ctrl), .idx_i(idx), .data_i(wdata),
    .cal_we_i(cal_upd_i && !set_mode_o), .cal_time_i(cal_time_i),
    .rd_byte_o(store_byte), .time_o(time_o), .alarm_o(alarm_o)
  );

  rtc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_a_i(wr_dat && sel_a), .wr_b_i(wr_dat && sel_b),
    .wr_cd_i(wr_dat && (sel_c || sel_d)), .rd_c_i(rd_dat && sel_c),
    .time_wr_i(wr_dat && sel_time), .wdata_i(wdata),
    .uip_set_i(uip_set_i), .uip_clr_i(uip_clr_i),
    .evt_per_i(evt_per_i), .evt_alm_i(evt_alm_i), .evt_upd_i(evt_upd_i),
    .reg_a_o(ctrl_a_o), .reg_b_o(ctrl_b_o), .reg_c_o(reg_c), .load_o(load_o)
  );

  assign irq_o      = reg_c[7];
  assign set_mode_o = ctrl_b_o[B_SET];

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      if (!addr)      rdata <= 8'hFF;
      else if (sel_a) rdata <= ctrl_a_o;
      else if (sel_b) rdata <= ctrl_b_o;
      else if (sel_c) rdata <= reg_c;
      else if (sel_d) rdata <= RST_CD;
      else            rdata <= store_byte;
    end
  end

  AST_EVEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !addr) |=> (rdata == 8'hFF)); // R1
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && sel_c && !evt_per_i && !evt_alm_i && !evt_upd_i) |=> !irq_o); // R5
  AST_FROZEN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_upd_i && set_mode_o && !wr_dat) |=> $stable(time_o)); // R11
endmodule

// File: tb/rtc_regport_test.sv
module rtc_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  localparam logic [1:0] OP_W = 2'd1, OP_R = 2'd2;
  // {op, addr, data, expected}
  localparam logic [18:0] VEC [NVEC] = '{
    {OP_W, 1'b0, 8'h0E, 8'h00},  // R2 select 14
    {OP_W, 1'b1, 8'h5A, 8'h00},
    {OP_R, 1'b1, 8'h00, 8'h5A},  // R2 readback
    {OP_W, 1'b0, 8'hFF, 8'h00},  // R1 index 0x7F
    {OP_W, 1'b1, 8'hC3, 8'h00},
    {OP_R, 1'b1, 8'h00, 8'hC3},  // R2 top byte
    {OP_W, 1'b0, 8'h8E, 8'h00},  // R1 bit 7 dropped
    {OP_R, 1'b1, 8'h00, 8'h5A},  // R1 alias to 14
    {OP_R, 1'b0, 8'h00, 8'hFF},  // R1 even read
    {OP_W, 1'b0, 8'h0A, 8'h00},
    {OP_W, 1'b1, 8'hFF, 8'h00},
    {OP_R, 1'b1, 8'h00, 8'h7F},  // R3 bit 7 kept at 0
    {OP_W, 1'b0, 8'h0C, 8'h00},
    {OP_W, 1'b1, 8'hFF, 8'h00},
    {OP_R, 1'b1, 8'h00, 8'h00},  // R4 C unchanged
    {OP_W, 1'b0, 8'h0D, 8'h00},
    {OP_W, 1'b1, 8'h00, 8'h00},
    {OP_R, 1'b1, 8'h00, 8'h80}   // R4 D unchanged
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, addr = 0;
  logic [7:0] wdata = '0, rdata;
  logic irq_o, evt_per_i = 0, evt_alm_i = 0, evt_upd_i = 0;
  logic uip_set_i = 0, uip_clr_i = 0, cal_upd_i = 0;
  logic [55:0] cal_time_i = '0, time_o;
  logic [23:0] alarm_o;
  logic [7:0] ctrl_a_o, ctrl_b_o;
  logic load_o, set_mode_o;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regport uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .evt_per_i(evt_per_i), .evt_alm_i(evt_alm_i), .evt_upd_i(evt_upd_i),
    .uip_set_i(uip_set_i), .uip_clr_i(uip_clr_i), .cal_upd_i(cal_upd_i),
    .cal_time_i(cal_time_i), .time_o(time_o), .alarm_o(alarm_o),
    .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o), .load_o(load_o), .set_mode_o(set_mode_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] op, input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = (op == OP_W); rd_en = (op == OP_R); addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rd_reg(input logic [7:0] ix);
    bus(OP_W, 1'b0, ix);
    bus(OP_R, 1'b1, 8'h00);
  endtask

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
    bus(OP_W, 1'b0, ix);
    bus(OP_W, 1'b1, d);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset values
    rd_reg(8'd10); chk("R9 A", rdata, 8'h26);
    rd_reg(8'd11); chk("R9 B", rdata, 8'h02);
    rd_reg(8'd12); chk("R9 C", rdata, 8'h00);
    rd_reg(8'd13); chk("R9 D", rdata, 8'h80);
    chk("R9 irq", irq_o, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      bus(VEC[k][18:17], VEC[k][16], VEC[k][15:8]);
      if (VEC[k][18:17] == OP_R)
        chk($sformatf("R1/R2/R3/R4 vec %0d", k), rdata, VEC[k][7:0]);
    end

    // R10 enabled periodic event, R5 clear on read
    wr_reg(8'd11, 8'h42);
    @(negedge clk); evt_per_i = 1; @(negedge clk); evt_per_i = 0;
    chk("R10 irq up", irq_o, 1'b1);
    rd_reg(8'd12); chk("R5 C value", rdata, 8'hC0);
    chk("R5 irq down", irq_o, 1'b0);
    rd_reg(8'd12); chk("R5 C cleared", rdata, 8'h00);
    // R10 disabled alarm event
    @(negedge clk); evt_alm_i = 1; @(negedge clk); evt_alm_i = 0;
    chk("R10 disabled irq", irq_o, 1'b0);
    rd_reg(8'd12); chk("R10 disabled C", rdata, 8'h00);

    // R11 uip set with SET low; R3 write keeps bit 7 high
    @(negedge clk); uip_set_i = 1; @(negedge clk); uip_set_i = 0;
    rd_reg(8'd10); chk("R11 uip set", rdata, 8'hFF);
    wr_reg(8'd10, 8'h00);
    rd_reg(8'd10); chk("R3 uip kept", rdata, 8'h80);

    // R6 SET write
    wr_reg(8'd11, 8'h92);
    rd_reg(8'd11); chk("R6 B masked", rdata, 8'h82);
    rd_reg(8'd10); chk("R6 uip cleared", rdata, 8'h00);
    chk("R6 set_mode", set_mode_o, 1'b1);

    // R8 frozen: time write gives no load
    wr_reg(8'd0, 8'h30); chk("R8 no load frozen", load_o, 1'b0);
    // R11 frozen: calendar update and uip set ignored
    @(negedge clk); cal_time_i = 56'h11_11_11_11_11_11_11; cal_upd_i = 1; uip_set_i = 1;
    @(negedge clk); cal_upd_i = 0; uip_set_i = 0;
    rd_reg(8'd0);  chk("R11 cal ignored", rdata, 8'h30);
    rd_reg(8'd10); chk("R11 uip ignored", rdata, 8'h00);

    // R7 leave SET
    wr_reg(8'd11, 8'h02); chk("R7 load pulse", load_o, 1'b1);
    @(negedge clk); chk("R7 pulse ends", load_o, 1'b0);
    // R8 time write while running
    wr_reg(8'd2, 8'h45); chk("R8 load pulse", load_o, 1'b1);
    wr_reg(8'd1, 8'h45); chk("R8 alarm byte no load", load_o, 1'b0);
    chk("R2 alarm out", alarm_o[7:0], 8'h45);

    // R11 calendar write-back while running
    @(negedge clk); cal_time_i = 56'h24_12_31_07_23_59_58; cal_upd_i = 1;
    @(negedge clk); cal_upd_i = 0;
    chk("R11 time_o", time_o, 56'h24_12_31_07_23_59_58);
    rd_reg(8'd9); chk("R11 year byte", rdata, 8'h24);
    @(negedge clk); uip_set_i = 1; @(negedge clk); uip_set_i = 0;
    @(negedge clk); uip_clr_i = 1; @(negedge clk); uip_clr_i = 0;
    rd_reg(8'd10); chk("R11 uip clr", rdata, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule